// File: doc/BRIEF.md
# Matrix Keypad Debounce Event Generator

This block watches the switch states of an 8-by-8 key matrix and turns each debounced change into a one-cycle event for a downstream event queue. The inputs are sampled statically. Each switch is a level that a capture stage in front of the block samples, and a `scan_tick` strobe marks each new sample. A switch whose level differs from its debounced state for a programmable number of consecutive ticks is accepted as changed. That accepted change becomes a press event, or a release event when release detection is enabled. Each event carries a 6-bit key index, numbered column-major.

Several keys may be accepted on the same tick. Their events are kept in a pending set and issued one per clock, lowest key index first. With autorepeat enabled, the most recently pressed key yields synthetic press events: the first after a programmable number of ticks, then one at a fixed tick interval. Any newly accepted change stops the repeat.

The block has two state machines. The output arbiter has three states:
- `ARB_IDLE`: no event this cycle.
- `ARB_EVENT`: issuing a pending press or release.
- `ARB_REPEAT`: issuing a repeat press.

Every cycle it moves to `ARB_EVENT` if any event is pending, otherwise to `ARB_REPEAT` if a repeat is requested, otherwise to `ARB_IDLE`.

The repeat timer also has three states:
- `RPT_OFF` goes to `RPT_DELAY` when a new press is issued.
- `RPT_DELAY` goes to `RPT_RATE` when the delay count expires, and that expiry requests a repeat.
- `RPT_RATE` stays in `RPT_RATE` and requests a repeat at each rate expiry.

Any state goes to `RPT_OFF` on an accepted change or when repeat is disabled. A new press issued in the same cycle as an accepted change takes precedence over the cancel.

Top module: `kp_event_gen`

## Requirements
- R1: Input bit `sw_mat[r*8+c]` is row r, column c; a level of 1 means the switch is closed. Its events carry key index c*8+r. For example, bit 1 is key 8, bit 7 is key 56 and bit 56 is key 7.
- R2: A change is accepted at the `deb_ticks`-th consecutive tick on which the switch differs from its debounced state. A `deb_ticks` value of 0 acts as 1. The event strobe is high in the second clock cycle after the cycle that carried the accepting tick.
- R3: A switch that returns to its debounced level before acceptance restarts its count from zero and produces no event.
- R4: Press events are always produced. Release events are produced only when `rel_en` is 1 at acceptance. A suppressed release still updates the debounced state, so a later press of that key is reported.
- R5: `evt_valid` is a one-cycle strobe per event. `evt_release` is 0 for a press, including a repeat, and 1 for a release.
- R6: Events pending at the same time are issued in consecutive cycles in ascending key-index order.
- R7: With `rpt_en` set, a repeat press of the last newly pressed key follows on the `rpt_delay`-th tick after its press event. Further repeats follow every `rpt_rate` ticks.
- R8: Any accepted change cancels the repeat timer. A press of a new key retargets the repeat to that key. After an accepted release no repeats occur until the next press.
- R9: Reset clears every debounced state to released. No event is produced during reset, and none follows reset while all switches are open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle strobe marking a new switch sample |
| sw_mat | input | 64 | Switch levels, bit r*8+c is row r column c, 1 = closed |
| deb_ticks | input | 8 | Debounce length in ticks |
| rel_en | input | 1 | Enable release events |
| rpt_en | input | 1 | Enable autorepeat |
| rpt_delay | input | 8 | Ticks from press to first repeat |
| rpt_rate | input | 8 | Ticks between later repeats |
| evt_valid | output | 1 | Event strobe |
| evt_key | output | 6 | Key index of the event |
| evt_release | output | 1 | 1 = release, 0 = press |

## Verification
The hardest situation to reach is the repeat timer being retargeted and then cancelled while a different key stays held. This needs a held key already in the rate phase, then a second press, then a suppressed release. The bench reaches it with a fixed debounce of one tick. It counts ticks exactly from the first press and compares the count of events per tick against the delay and rate settings. It then shows that the still-held first key stays silent. The debounce restart is covered by table rows that stop one tick short of acceptance, revert, and then resume.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_EVENT  = 2'd1,
        ARB_REPEAT = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        RPT_OFF   = 2'd0,
        RPT_DELAY = 2'd1,
        RPT_RATE  = 2'd2
    } rpt_state_t;

endpackage

// File: rtl/kp_debounce.sv
module kp_debounce #(
    parameter int DEB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [DEB_W-1:0] deb_ticks,
    input  logic             hold,
    output logic             stable,
    output logic             confirm
);

    logic [DEB_W-1:0] cnt_q;
    logic             st_q;
    logic [DEB_W:0]   cnt_nxt;
    logic             reach;

    assign cnt_nxt = {1'b0, cnt_q} + {{DEB_W{1'b0}}, 1'b1};
    assign reach   = cnt_nxt >= {1'b0, deb_ticks};
    assign confirm = tick && (raw != st_q) && !hold && reach;
    assign stable  = st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= 1'b0;
        end else if (tick) begin
            if (raw == st_q) begin
                cnt_q <= '0;
            end else if (hold) begin
                cnt_q <= cnt_q;
            end else if (reach) begin
                st_q  <= raw;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_nxt[DEB_W-1:0];
            end
        end
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) hold |=> st_q == $past(st_q)); // R2

endmodule

// File: rtl/kp_repeat.sv
module kp_repeat
    import kp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int RPT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rpt_en,
    input  logic [RPT_W-1:0] rpt_delay,
    input  logic [RPT_W-1:0] rpt_rate,
    input  logic             start,
    input  logic [IDX_W-1:0] start_key,
    input  logic             cancel,
    input  logic             ack,
    output logic             req,
    output logic [IDX_W-1:0] key
);

    rpt_state_t       st_q, st_d;
    logic [RPT_W-1:0] cnt_q;
    logic [RPT_W:0]   cnt_nxt;
    logic [RPT_W-1:0] limit;
    logic             fire;
    logic             req_q;
    logic [IDX_W-1:0] key_q;

    assign limit   = (st_q == RPT_DELAY) ? rpt_delay : rpt_rate;
    assign cnt_nxt = {1'b0, cnt_q} + {{RPT_W{1'b0}}, 1'b1};
    assign fire    = tick && (st_q != RPT_OFF) && (cnt_nxt >= {1'b0, limit});

    always_comb begin
        st_d = st_q;
        if (!rpt_en) begin
            st_d = RPT_OFF;
        end else if (start) begin
            st_d = RPT_DELAY;
        end else if (cancel) begin
            st_d = RPT_OFF;
        end else begin
            unique case (st_q)
                RPT_OFF:   st_d = RPT_OFF;
                RPT_DELAY: st_d = fire ? RPT_RATE : RPT_DELAY;
                RPT_RATE:  st_d = RPT_RATE;
                default:   st_d = RPT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RPT_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
            key_q <= '0;
        end else begin
            if (start) key_q <= start_key;
            if (!rpt_en || start || cancel) begin
                cnt_q <= '0;
                req_q <= 1'b0;
            end else begin
                if (fire)                              cnt_q <= '0;
                else if (tick && st_q != RPT_OFF)      cnt_q <= cnt_nxt[RPT_W-1:0];
                if (fire)     req_q <= 1'b1;
                else if (ack) req_q <= 1'b0;
            end
        end
    end

    assign req = req_q;
    assign key = key_q;

    AST_REQ_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n) req_q |-> st_q != RPT_OFF); // R8
    AST_DISABLE_STOPS:   assert property (@(posedge clk) disable iff (!rst_n) !rpt_en |=> st_q == RPT_OFF && !req_q); // R7

endmodule

// File: rtl/kp_arbiter.sv
module kp_arbiter
    import kp_pkg::*;
#(
    parameter int NKEYS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NKEYS-1:0] set_vec,
    input  logic [NKEYS-1:0] stable_vec,
    input  logic             rpt_req,
    input  logic [IDX_W-1:0] rpt_key,
    output logic [NKEYS-1:0] pend,
    output logic             rpt_ack,
    output logic             new_press,
    output logic [IDX_W-1:0] new_key,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_key,
    output logic             evt_release
);

    arb_state_t       st_q, st_d;
    logic [NKEYS-1:0] pend_q;
    logic [NKEYS-1:0] clr_vec;
    logic [IDX_W-1:0] low_idx;
    logic [IDX_W-1:0] key_q;
    logic             rel_q;

    always_comb begin
        low_idx = '0;
        for (int i = NKEYS - 1; i >= 0; i--) begin
            if (pend_q[i]) low_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (|pend_q)      st_d = ARB_EVENT;
        else if (rpt_req) st_d = ARB_REPEAT;
        else              st_d = ARB_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ARB_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        clr_vec = '0;
        if (st_d == ARB_EVENT) clr_vec[low_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            rel_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            unique case (st_d)
                ARB_IDLE: begin
                    key_q <= key_q;
                    rel_q <= rel_q;
                end
                ARB_EVENT: begin
                    key_q <= low_idx;
                    rel_q <= ~stable_vec[low_idx];
                end
                ARB_REPEAT: begin
                    key_q <= rpt_key;
                    rel_q <= 1'b0;
                end
                default: begin
                    key_q <= key_q;
                    rel_q <= rel_q;
                end
            endcase
        end
    end

    assign pend        = pend_q;
    assign rpt_ack     = (st_d == ARB_REPEAT);
    assign new_press   = (st_d == ARB_EVENT) && stable_vec[low_idx];
    assign new_key     = low_idx;
    assign evt_valid   = (st_q != ARB_IDLE);
    assign evt_key     = key_q;
    assign evt_release = rel_q;

    AST_EVENT_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) st_q == ARB_EVENT |-> $past(pend_q) != '0); // R6
    AST_EVENT_RETIRED:     assert property (@(posedge clk) disable iff (!rst_n) st_q == ARB_EVENT |-> !pend_q[key_q]); // R6
    AST_REPEAT_IS_PRESS:   assert property (@(posedge clk) disable iff (!rst_n) st_q == ARB_REPEAT |-> !rel_q); // R5

endmodule

// File: rtl/kp_event_gen.sv
module kp_event_gen
    import kp_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int DEB_W = 8,
    parameter int RPT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scan_tick,
    input  logic [ROWS*COLS-1:0]      sw_mat,
    input  logic [DEB_W-1:0]          deb_ticks,
    input  logic                      rel_en,
    input  logic                      rpt_en,
    input  logic [RPT_W-1:0]          rpt_delay,
    input  logic [RPT_W-1:0]          rpt_rate,
    output logic                      evt_valid,
    output logic [$clog2(ROWS*COLS)-1:0] evt_key,
    output logic                      evt_release
);

    localparam int NKEYS = ROWS * COLS;
    localparam int IDX_W = $clog2(NKEYS);

    logic [NKEYS-1:0] raw_key;
    logic [NKEYS-1:0] stable_vec;
    logic [NKEYS-1:0] confirm_vec;
    logic [NKEYS-1:0] set_vec;
    logic [NKEYS-1:0] pend;
    logic             rpt_req;
    logic             rpt_ack;
    logic [IDX_W-1:0] rpt_key;
    logic             new_press;
    logic [IDX_W-1:0] new_key;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int KEY = c * ROWS + r;
            assign raw_key[KEY] = sw_mat[r * COLS + c];
            assign set_vec[KEY] = confirm_vec[KEY] && (raw_key[KEY] || rel_en);

            kp_debounce #(.DEB_W(DEB_W)) u_deb (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (scan_tick),
                .raw       (raw_key[KEY]),
                .deb_ticks (deb_ticks),
                .hold      (pend[KEY]),
                .stable    (stable_vec[KEY]),
                .confirm   (confirm_vec[KEY])
            );
        end
    end

    kp_arbiter #(.NKEYS(NKEYS), .IDX_W(IDX_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vec     (set_vec),
        .stable_vec  (stable_vec),
        .rpt_req     (rpt_req),
        .rpt_key     (rpt_key),
        .pend        (pend),
        .rpt_ack     (rpt_ack),
        .new_press   (new_press),
        .new_key     (new_key),
        .evt_valid   (evt_valid),
        .evt_key     (evt_key),
        .evt_release (evt_release)
    );

    kp_repeat #(.IDX_W(IDX_W), .RPT_W(RPT_W)) u_rpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (scan_tick),
        .rpt_en    (rpt_en),
        .rpt_delay (rpt_delay),
        .rpt_rate  (rpt_rate),
        .start     (new_press),
        .start_key (new_key),
        .cancel    (|confirm_vec),
        .ack       (rpt_ack),
        .req       (rpt_req),
        .key       (rpt_key)
    );

endmodule

// File: tb/tb_kp_event_gen.sv
`timescale 1ns/1ps
module tb_kp_event_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_tick;
    logic [63:0] sw_mat;
    logic [7:0]  deb_ticks;
    logic        rel_en;
    logic        rpt_en;
    logic [7:0]  rpt_delay;
    logic [7:0]  rpt_rate;
    logic        evt_valid;
    logic [5:0]  evt_key;
    logic        evt_release;

    always #4 clk = ~clk;

    kp_event_gen dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .sw_mat(sw_mat),
        .deb_ticks(deb_ticks), .rel_en(rel_en), .rpt_en(rpt_en),
        .rpt_delay(rpt_delay), .rpt_rate(rpt_rate),
        .evt_valid(evt_valid), .evt_key(evt_key), .evt_release(evt_release)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int          ev_n;
    logic [5:0]  ev_first, ev_last;
    logic        ev_first_rel;
    int          ev_bad_order;

    always @(negedge clk) begin
        cycles++;
        if (evt_valid) begin
            if (ev_n == 0) begin
                ev_first     = evt_key;
                ev_first_rel = evt_release;
            end else if (evt_key <= ev_last) begin
                ev_bad_order++;
            end
            ev_last = evt_key;
            ev_n++;
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        ev_n = 0; ev_first = '0; ev_last = '0; ev_first_rel = 1'b0; ev_bad_order = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) scan_tick = 1'b1;
            @(negedge clk) scan_tick = 1'b0;
            repeat (80) @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [63:0] keys;
        logic        rel;
        logic [7:0]  nt;
        logic [7:0]  nev;
        logic [5:0]  k0;
        logic        r0;
        logic [5:0]  kl;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{64'h0000_0100_0000_0000, 1'b1, 8'd2, 8'd0, 6'd0,  1'b0, 6'd0,  8'd2}, // R2: short of count
        '{64'h0000_0000_0000_0000, 1'b1, 8'd1, 8'd0, 6'd0,  1'b0, 6'd0,  8'd3}, // R3: revert
        '{64'h0000_0100_0000_0000, 1'b1, 8'd2, 8'd0, 6'd0,  1'b0, 6'd0,  8'd3}, // R3: count restarted
        '{64'h0000_0100_0000_0000, 1'b1, 8'd1, 8'd1, 6'd5,  1'b0, 6'd5,  8'd1}, // R1 R2: key 5
        '{64'h8100_0100_0000_0281, 1'b1, 8'd3, 8'd5, 6'd0,  1'b0, 6'd63, 8'd6}, // R6 R1: 0,7,9,56,63
        '{64'h0000_0000_0000_0200, 1'b1, 8'd3, 8'd5, 6'd0,  1'b1, 6'd63, 8'd5}, // R5: releases
        '{64'h0000_0000_0000_0000, 1'b0, 8'd3, 8'd0, 6'd0,  1'b0, 6'd0,  8'd4}, // R4: release muted
        '{64'h0000_0000_0000_0200, 1'b0, 8'd3, 8'd1, 6'd9,  1'b0, 6'd9,  8'd4}, // R4: re-press seen
        '{64'h0000_0000_0000_0000, 1'b1, 8'd3, 8'd1, 6'd9,  1'b1, 6'd9,  8'd5}  // R5: release seen
    };

    initial begin
        rst_n = 1'b0; scan_tick = 1'b0; sw_mat = '1;
        deb_ticks = 8'd3; rel_en = 1'b1; rpt_en = 1'b0;
        rpt_delay = 8'd4; rpt_rate = 8'd2;
        clear_log();

        // R9: no events during reset with every switch closed and ticks running
        for (int i = 0; i < 12; i++) begin
            @(negedge clk) scan_tick = ~scan_tick;
        end
        chk("R9 reset events", ev_n, 0);
        @(negedge clk) begin scan_tick = 1'b0; sw_mat = '0; end
        @(negedge clk) rst_n = 1'b1;
        chk("R9 strobe after reset", evt_valid, 0);
        clear_log();
        ticks(5);
        chk("R9 released after reset", ev_n, 0);

        foreach (VECS[v]) begin
            sw_mat = VECS[v].keys;
            rel_en = VECS[v].rel;
            clear_log();
            ticks(int'(VECS[v].nt));
            chk($sformatf("R%0d row %0d count", VECS[v].rq, v), ev_n, VECS[v].nev);
            if (VECS[v].nev != 0) begin
                chk($sformatf("R%0d row %0d first key", VECS[v].rq, v), ev_first, VECS[v].k0);
                chk($sformatf("R%0d row %0d kind", VECS[v].rq, v), ev_first_rel, VECS[v].r0);
                chk($sformatf("R%0d row %0d last key", VECS[v].rq, v), ev_last, VECS[v].kl);
                chk($sformatf("R6 row %0d ascending", v), ev_bad_order, 0);
            end
        end

        // R2 timing and R7 repeat: debounce 1, delay 4, rate 2, releases muted
        deb_ticks = 8'd1; rel_en = 1'b0; rpt_en = 1'b1;
        clear_log();
        sw_mat = 64'h0000_0004_0000_0000; // row 4 col 2 -> key 20
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) begin
            scan_tick = 1'b0;
            chk("R2 strobe one cycle after tick", evt_valid, 0);
        end
        @(negedge clk) begin
            chk("R2 strobe second cycle after tick", evt_valid, 1);
            chk("R1 key 20", evt_key, 20);
        end
        @(negedge clk) chk("R5 strobe lasts one cycle", evt_valid, 0);
        repeat (80) @(negedge clk);
        chk("R7 press count", ev_n, 1);
        clear_log(); ticks(3);
        chk("R7 silent before delay", ev_n, 0);
        clear_log(); ticks(1);
        chk("R7 repeat at delay", ev_n, 1);
        chk("R7 repeat key", ev_first, 20);
        chk("R5 repeat is press", ev_first_rel, 0);
        clear_log(); ticks(1);
        chk("R7 silent inside rate", ev_n, 0);
        clear_log(); ticks(1);
        chk("R7 repeat at rate", ev_n, 1);

        // R8: new press retargets, accepted release cancels
        sw_mat = 64'h0000_0004_0100_0000; // adds row 3 col 0 -> key 3
        clear_log(); ticks(1);
        chk("R8 new press count", ev_n, 1);
        chk("R8 new press key", ev_first, 3);
        clear_log(); ticks(3);
        chk("R8 retarget delay silent", ev_n, 0);
        clear_log(); ticks(1);
        chk("R8 retarget repeat count", ev_n, 1);
        chk("R8 retarget repeat key", ev_first, 3);
        sw_mat = 64'h0000_0004_0000_0000;
        clear_log(); ticks(7);
        chk("R8 cancelled after release", ev_n, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule